// File: doc/BRIEF.md
# Inflight Packet Credit Release Unit

This block tracks how many packets are outstanding against each load-balancer bucket and against each notification ring. Packet arrivals raise those counts by one. Software lowers them with a single memory-mapped write whose address carries everything needed to decode the release: a region selector, a ring index, a bucket index, two independent enable bits and a service-domain index. The low 16 bits of the write data give the number of packets being released.

Each bucket has a status entry holding its assigned ring, a reference count, a group and a mode. The reference count is the bucket's in-flight count. Per-ring in-flight counts sit in a separate counter bank. Both structures can be written and read through an initialisation port. A structure select picks the target and an index picks the entry. The full bucket table depth is 4160 entries. The depth is a parameter, and its default is reduced so that the design elaborates quickly.

A release that would push a count below zero leaves that count at zero and sets a sticky underflow flag. An arrival and a release that hit the same entry in the same cycle are merged into one net update.

Top module: `crp_release_unit`

## Requirements
- R1: A release write is accepted only when address bits 28:26 equal 4. Any other value changes no count and gives no acknowledge.
- R2: The ring index comes from address bits 10:3. The bucket index comes from address bits 23:11.
- R3: Address bit 24 enables the ring release and address bit 25 enables the bucket release. Either one, both or neither may be set, and each acts on its own target only.
- R4: Write data bits 15:0 give a count that is subtracted from the in-flight count of every enabled target.
- R5: A release larger than the current count leaves that count at 0. It also sets a sticky flag, `bkt_uflow` for a bucket and `ring_uflow` for a ring. A flag clears only on reset.
- R6: An arrival adds one to its bucket or ring count. When an arrival and a release hit the same entry in the same cycle, the result is count + 1 - release, held within 0 to 0xFFFF.
- R7: A bucket entry is 32 bits: assigned ring in bits 7:0, reference count in bits 23:8, group in bits 28:24 and mode in bits 31:29. Releases and arrivals change only the reference count.
- R8: Init select code 1 addresses the bucket table and code 2 addresses the ring counters. A ring counter reads zero-extended from bits 15:0. Codes 0 and 3 read 0. Read data appears one cycle after the index is presented. An init write overrides a release or arrival to the same entry in the same cycle.
- R9: `rel_ack` pulses in the cycle after an accepted write, and `rel_svc_dom` then holds address bits 39:35.
- R10: Indices at or beyond the configured depth are ignored by releases, arrivals and init writes, and they read as 0.
- R11: After reset every count, attribute, flag, acknowledge and read data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rel_valid | input | 1 | Release write strobe |
| rel_addr | input | 40 | Release write address |
| rel_data | input | 16 | Number of packets released |
| arr_bkt_valid | input | 1 | Packet arrival on a bucket |
| arr_bkt_idx | input | 13 | Bucket of the arrival |
| arr_ring_valid | input | 1 | Packet arrival on a ring |
| arr_ring_idx | input | 8 | Ring of the arrival |
| init_sel | input | 2 | Structure select: 1 bucket table, 2 ring counters |
| init_idx | input | 13 | Entry index for init read and write |
| init_wr | input | 1 | Init write strobe |
| init_wdata | input | 32 | Init write data |
| init_rdata | output | 32 | Init read data, one cycle after index |
| rel_ack | output | 1 | Accepted release acknowledge |
| rel_svc_dom | output | 5 | Service-domain index of acknowledged release |
| bkt_uflow | output | 1 | Sticky bucket underflow flag |
| ring_uflow | output | 1 | Sticky ring underflow flag |

## Verification
The embedded properties check on every cycle that an acknowledge only follows a write to the correct region and carries its service-domain field. They also check that an underflow flag never clears once set, that counts hold when no release, arrival or write is presented, and that bucket attributes move only on an init write. The bench scenarios are needed for the arithmetic itself: clamping at zero, saturating at the top and merging a same-cycle arrival with a release. The scenarios also cover the independence of the two enable bits, the out-of-range indices, and the priority of an init write over a release. A long random run compared against a bench model exercises these effects together.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int ADDR_W     = 40;
  localparam int RING_IDX_W = 8;
  localparam int BKT_IDX_W  = 13;
  localparam int CNT_W      = 16;
  localparam int SVC_W      = 5;
  localparam int ENT_W      = 32;

  // Address field positions
  localparam int RING_LSB    = 3;
  localparam int BKT_LSB     = 11;
  localparam int RING_EN_BIT = 24;
  localparam int BKT_EN_BIT  = 25;
  localparam int REGION_LSB  = 26;
  localparam int SVC_LSB     = 35;
  localparam logic [2:0] REGION_RELEASE = 3'd4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BKT  = 2'd1,
    SEL_RING = 2'd2,
    SEL_RSVD = 2'd3
  } tbl_sel_e;

  typedef struct packed {
    logic [2:0]       mode;
    logic [4:0]       group;
    logic [CNT_W-1:0] refcnt;
    logic [7:0]       ring;
  } bkt_entry_t;

  typedef struct packed {
    logic             uflow;
    logic [CNT_W-1:0] val;
  } cnt_upd_t;

  // Net update: cur + inc - dec, clamped to [0, max]
  function automatic cnt_upd_t cnt_step(input logic [CNT_W-1:0] cur,
                                        input logic             inc,
                                        input logic [CNT_W-1:0] dec);
    logic [CNT_W:0] up;
    logic [CNT_W:0] diff;
    cnt_upd_t       r;
    up      = {1'b0, cur} + {{CNT_W{1'b0}}, inc};
    diff    = up - {1'b0, dec};
    r.uflow = ({1'b0, dec} > up);
    if (r.uflow)          r.val = '0;
    else if (diff[CNT_W]) r.val = '1;
    else                  r.val = diff[CNT_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/crp_rel_decode.sv
module crp_rel_decode
  import crp_pkg::*;
(
  input  logic                  valid,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  accept,
  output logic                  ring_go,
  output logic                  bkt_go,
  output logic [RING_IDX_W-1:0] ring_idx,
  output logic [BKT_IDX_W-1:0]  bkt_idx,
  output logic [SVC_W-1:0]      svc
);
  logic region_ok;

  always_comb begin
    region_ok = (addr[REGION_LSB +: 3] == REGION_RELEASE);
    accept    = valid && region_ok;
    ring_go   = accept && addr[RING_EN_BIT];
    bkt_go    = accept && addr[BKT_EN_BIT];
    ring_idx  = addr[RING_LSB +: RING_IDX_W];
    bkt_idx   = addr[BKT_LSB +: BKT_IDX_W];
    svc       = addr[SVC_LSB +: SVC_W];
  end
endmodule

// File: rtl/crp_cnt_bank.sv
module crp_cnt_bank
  import crp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic [CNT_W-1:0] rel_cnt,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_val,
  output logic             uflow
);
  logic [DEPTH-1:0][CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0][CNT_W-1:0] cnt_d;
  logic [DEPTH-1:0]            uf_vec;
  logic                        upd_en;
  logic                        uflow_q;
  logic                        uflow_d;
  cnt_upd_t                    upd_v;
  logic                        hit_rel;
  logic                        hit_inc;
  logic                        hit_wr;

  // Next-state for every entry
  always_comb begin
    cnt_d   = cnt_q;
    uf_vec  = '0;
    upd_v   = '0;
    hit_rel = 1'b0;
    hit_inc = 1'b0;
    hit_wr  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_rel = rel_en && (rel_idx == IDX_W'(i));
      hit_inc = inc_en && (inc_idx == IDX_W'(i));
      hit_wr  = wr_en  && (wr_idx  == IDX_W'(i));
      upd_v   = cnt_step(cnt_q[i], hit_inc, hit_rel ? rel_cnt : '0);
      if (hit_wr) begin
        cnt_d[i] = wr_val;
      end else begin
        cnt_d[i]  = upd_v.val;
        uf_vec[i] = upd_v.uflow;
      end
    end
    upd_en  = rel_en || inc_en || wr_en;
    uflow_d = uflow_q || (|uf_vec);
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_val = cnt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      uflow_q <= 1'b0;
    end else begin
      if (upd_en) cnt_q <= cnt_d;
      uflow_q <= uflow_d;
    end
  end

  assign uflow = uflow_q;

  p_uflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_q |=> uflow_q)
    else $error("underflow flag cleared without reset");

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_en && !inc_en && !wr_en) |=> $stable(cnt_q))
    else $error("count changed with no stimulus");
endmodule

// File: rtl/crp_bkt_table.sv
module crp_bkt_table
  import crp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic [CNT_W-1:0] rel_cnt,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  bkt_entry_t       wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output bkt_entry_t       rd_ent,
  output logic             uflow
);
  localparam int ATTR_W = ENT_W - CNT_W;

  logic [DEPTH-1:0][ATTR_W-1:0] attr_q;
  logic [DEPTH-1:0][ATTR_W-1:0] attr_d;
  logic [ATTR_W-1:0]            attr_rd;
  logic [CNT_W-1:0]             cnt_rd;

  crp_cnt_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rel_en  (rel_en),
    .rel_idx (rel_idx),
    .rel_cnt (rel_cnt),
    .inc_en  (inc_en),
    .inc_idx (inc_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_val  (wr_ent.refcnt),
    .rd_idx  (rd_idx),
    .rd_val  (cnt_rd),
    .uflow   (uflow)
  );

  always_comb begin
    attr_d  = attr_q;
    attr_rd = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i)))
        attr_d[i] = {wr_ent.mode, wr_ent.group, wr_ent.ring};
      if (rd_idx == IDX_W'(i)) attr_rd = attr_q[i];
    end
    rd_ent        = '0;
    rd_ent.mode   = attr_rd[ATTR_W-1 -: 3];
    rd_ent.group  = attr_rd[ATTR_W-4 -: 5];
    rd_ent.ring   = attr_rd[7:0];
    rd_ent.refcnt = cnt_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
    end else if (wr_en) begin
      attr_q <= attr_d;
    end
  end

  p_attr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(attr_q))
    else $error("bucket attributes changed without init write");
endmodule

// File: rtl/crp_release_unit.sv
module crp_release_unit
  import crp_pkg::*;
#(
  parameter int BKT_DEPTH  = 64,
  parameter int RING_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rel_valid,
  input  logic [39:0] rel_addr,
  input  logic [15:0] rel_data,
  input  logic        arr_bkt_valid,
  input  logic [12:0] arr_bkt_idx,
  input  logic        arr_ring_valid,
  input  logic [7:0]  arr_ring_idx,
  input  logic [1:0]  init_sel,
  input  logic [12:0] init_idx,
  input  logic        init_wr,
  input  logic [31:0] init_wdata,
  output logic [31:0] init_rdata,
  output logic        rel_ack,
  output logic [4:0]  rel_svc_dom,
  output logic        bkt_uflow,
  output logic        ring_uflow
);
  localparam int HI_W = BKT_IDX_W - RING_IDX_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  logic                  dec_accept;
  logic                  dec_ring_go;
  logic                  dec_bkt_go;
  logic [RING_IDX_W-1:0] dec_ring_idx;
  logic [BKT_IDX_W-1:0]  dec_bkt_idx;
  logic [SVC_W-1:0]      dec_svc;

  crp_rel_decode u_dec (
    .valid    (rel_valid),
    .addr     (rel_addr),
    .accept   (dec_accept),
    .ring_go  (dec_ring_go),
    .bkt_go   (dec_bkt_go),
    .ring_idx (dec_ring_idx),
    .bkt_idx  (dec_bkt_idx),
    .svc      (dec_svc)
  );

  // Init port steering
  logic                  bkt_wr;
  logic                  ring_wr;
  logic                  ring_idx_ok;
  logic [RING_IDX_W-1:0] init_ring_idx;

  always_comb begin
    ring_idx_ok   = (init_idx[BKT_IDX_W-1 -: HI_W] == '0);
    init_ring_idx = init_idx[RING_IDX_W-1:0];
    bkt_wr        = init_wr && (tbl_sel_e'(init_sel) == SEL_BKT);
    ring_wr       = init_wr && (tbl_sel_e'(init_sel) == SEL_RING) && ring_idx_ok;
  end

  bkt_entry_t       bkt_rd_ent;
  logic [CNT_W-1:0] ring_rd_val;

  crp_bkt_table #(.DEPTH(BKT_DEPTH), .IDX_W(BKT_IDX_W)) u_bkt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rel_en  (dec_bkt_go),
    .rel_idx (dec_bkt_idx),
    .rel_cnt (rel_data),
    .inc_en  (arr_bkt_valid),
    .inc_idx (arr_bkt_idx),
    .wr_en   (bkt_wr),
    .wr_idx  (init_idx),
    .wr_ent  (bkt_entry_t'(init_wdata)),
    .rd_idx  (init_idx),
    .rd_ent  (bkt_rd_ent),
    .uflow   (bkt_uflow)
  );

  crp_cnt_bank #(.DEPTH(RING_DEPTH), .IDX_W(RING_IDX_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rel_en  (dec_ring_go),
    .rel_idx (dec_ring_idx),
    .rel_cnt (rel_data),
    .inc_en  (arr_ring_valid),
    .inc_idx (arr_ring_idx),
    .wr_en   (ring_wr),
    .wr_idx  (init_ring_idx),
    .wr_val  (init_wdata[CNT_W-1:0]),
    .rd_idx  (init_ring_idx),
    .rd_val  (ring_rd_val),
    .uflow   (ring_uflow)
  );

  // Output registers
  logic [ENT_W-1:0] rdata_d;

  always_comb begin
    unique case (tbl_sel_e'(init_sel))
      SEL_BKT:  rdata_d = ENT_W'(bkt_rd_ent);
      SEL_RING: rdata_d = ring_idx_ok ? {{(ENT_W-CNT_W){1'b0}}, ring_rd_val} : '0;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      init_rdata  <= '0;
      rel_ack     <= 1'b0;
      rel_svc_dom <= '0;
    end else begin
      init_rdata <= rdata_d;
      rel_ack    <= dec_accept;
      if (dec_accept) rel_svc_dom <= dec_svc;
    end
  end

  p_ack_region_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    rel_ack |-> ($past(rel_valid) && ($past(rel_addr[28:26]) == 3'd4)))
    else $error("acknowledge without a release-region write");

  p_svc_field_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rel_ack |-> (rel_svc_dom == $past(rel_addr[39:35])))
    else $error("service domain does not match address");
endmodule

// File: tb/sim_crp_release_unit.sv
`timescale 1ns/1ps
module sim_crp_release_unit;
  localparam int BD = 64;
  localparam int RD = 32;

  logic        clk;
  logic        rst_n;
  logic        rel_valid;
  logic [39:0] rel_addr;
  logic [15:0] rel_data;
  logic        arr_bkt_valid;
  logic [12:0] arr_bkt_idx;
  logic        arr_ring_valid;
  logic [7:0]  arr_ring_idx;
  logic [1:0]  init_sel;
  logic [12:0] init_idx;
  logic        init_wr;
  logic [31:0] init_wdata;
  logic [31:0] init_rdata;
  logic        rel_ack;
  logic [4:0]  rel_svc_dom;
  logic        bkt_uflow;
  logic        ring_uflow;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [31:0] m_bkt  [BD];
  logic [15:0] m_ring [RD];
  bit          m_bu;
  bit          m_ru;

  crp_release_unit #(.BKT_DEPTH(BD), .RING_DEPTH(RD)) u0 (
    .clk(clk), .rst_n(rst_n), .rel_valid(rel_valid), .rel_addr(rel_addr),
    .rel_data(rel_data), .arr_bkt_valid(arr_bkt_valid), .arr_bkt_idx(arr_bkt_idx),
    .arr_ring_valid(arr_ring_valid), .arr_ring_idx(arr_ring_idx),
    .init_sel(init_sel), .init_idx(init_idx), .init_wr(init_wr),
    .init_wdata(init_wdata), .init_rdata(init_rdata), .rel_ack(rel_ack),
    .rel_svc_dom(rel_svc_dom), .bkt_uflow(bkt_uflow), .ring_uflow(ring_uflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] mk_addr(input logic [2:0] region, input bit ren,
                                          input bit ben, input logic [7:0] ridx,
                                          input logic [12:0] bidx, input logic [4:0] svc);
    logic [39:0] a;
    a        = '0;
    a[10:3]  = ridx;
    a[23:11] = bidx;
    a[24]    = ren;
    a[25]    = ben;
    a[28:26] = region;
    a[39:35] = svc;
    return a;
  endfunction

  // {underflow, value}
  function automatic logic [16:0] net(input logic [15:0] cur, input bit inc,
                                      input logic [15:0] dec);
    int v;
    v = int'(cur) + (inc ? 1 : 0) - int'(dec);
    if (v < 0)      return {1'b1, 16'h0};
    if (v > 65535)  return {1'b0, 16'hFFFF};
    return {1'b0, 16'(v)};
  endfunction

  task automatic idle_inputs();
    rel_valid = 0; rel_addr = '0; rel_data = '0;
    arr_bkt_valid = 0; arr_bkt_idx = '0; arr_ring_valid = 0; arr_ring_idx = '0;
    init_wr = 0; init_sel = 2'd0; init_idx = '0; init_wdata = '0;
  endtask

  // Drive one cycle of stimulus at a negedge, update the model, check ack after the edge
  task automatic cyc(input bit rv, input logic [39:0] a, input logic [15:0] d,
                     input bit abv, input logic [12:0] abi,
                     input bit arv, input logic [7:0] ari,
                     input bit iw, input logic [1:0] isel, input logic [12:0] iidx,
                     input logic [31:0] iwd, input string req);
    bit acc, r_go, b_go;
    int ri, bi;
    logic [16:0] u;
    rel_valid = rv; rel_addr = a; rel_data = d;
    arr_bkt_valid = abv; arr_bkt_idx = abi; arr_ring_valid = arv; arr_ring_idx = ari;
    init_wr = iw; init_sel = isel; init_idx = iidx; init_wdata = iwd;
    acc  = rv && (a[28:26] == 3'd4);
    r_go = acc && a[24];
    b_go = acc && a[25];
    ri   = int'(a[10:3]);
    bi   = int'(a[23:11]);
    for (int i = 0; i < RD; i++) begin
      u = net(m_ring[i], arv && (int'(ari) == i), (r_go && ri == i) ? d : 16'h0);
      if (iw && isel == 2'd2 && int'(iidx) == i) m_ring[i] = iwd[15:0];
      else begin m_ring[i] = u[15:0]; if (u[16]) m_ru = 1; end
    end
    for (int i = 0; i < BD; i++) begin
      u = net(m_bkt[i][23:8], abv && (int'(abi) == i), (b_go && bi == i) ? d : 16'h0);
      if (iw && isel == 2'd1 && int'(iidx) == i) m_bkt[i] = iwd;
      else begin m_bkt[i][23:8] = u[15:0]; if (u[16]) m_bu = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    check(req, "rel_ack", {31'b0, rel_ack}, {31'b0, acc});
    if (acc) check("R9", "rel_svc_dom", {27'b0, rel_svc_dom}, {27'b0, a[39:35]});
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [12:0] idx,
                        input logic [31:0] exp, input string req);
    init_sel = sel; init_idx = idx; init_wr = 0;
    @(posedge clk);
    @(negedge clk);
    check(req, $sformatf("read sel%0d idx%0d", sel, idx), init_rdata, exp);
    init_sel = 2'd0; init_idx = '0;
  endtask

  task automatic release_only(input logic [39:0] a, input logic [15:0] d, input string req);
    cyc(1, a, d, 0, '0, 0, '0, 0, 2'd0, '0, '0, req);
  endtask

  task automatic init_write(input logic [1:0] sel, input logic [12:0] idx,
                            input logic [31:0] w, input string req);
    cyc(0, '0, '0, 0, '0, 0, '0, 1, sel, idx, w, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < BD; i++) m_bkt[i] = '0;
    for (int i = 0; i < RD; i++) m_ring[i] = '0;
    m_bu = 0; m_ru = 0;
    idle_inputs();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11", "init_rdata", init_rdata, 32'h0);
    check("R11", "rel_ack", {31'b0, rel_ack}, 32'h0);
    check("R11", "flags", {30'b0, bkt_uflow, ring_uflow}, 32'h0);
    rd_chk(2'd1, 13'd0, 32'h0, "R11");
    rd_chk(2'd2, 13'd0, 32'h0, "R11");

    // R7, R8: bucket entry layout and readback
    init_write(2'd1, 13'd5, {3'd5, 5'd17, 16'd100, 8'd7}, "R7");
    rd_chk(2'd1, 13'd5, {3'd5, 5'd17, 16'd100, 8'd7}, "R7");

    // R2, R4, R9: bucket-only release
    release_only(mk_addr(3'd4, 0, 1, 8'd7, 13'd5, 5'h15), 16'd30, "R4");
    rd_chk(2'd1, 13'd5, {3'd5, 5'd17, 16'd70, 8'd7}, "R4");
    rd_chk(2'd2, 13'd7, 32'h0, "R3");

    // R1: wrong region with both enables does nothing
    init_write(2'd2, 13'd9, 32'd50, "R8");
    release_only(mk_addr(3'd3, 1, 1, 8'd9, 13'd5, 5'h3), 16'd10, "R1");
    rd_chk(2'd1, 13'd5, m_bkt[5], "R1");
    rd_chk(2'd2, 13'd9, 32'd50, "R1");

    // R3: both enables
    release_only(mk_addr(3'd4, 1, 1, 8'd9, 13'd5, 5'h1F), 16'd20, "R3");
    rd_chk(2'd2, 13'd9, 32'd30, "R3");
    rd_chk(2'd1, 13'd5, {3'd5, 5'd17, 16'd50, 8'd7}, "R3");
    // R3: ring only
    release_only(mk_addr(3'd4, 1, 0, 8'd9, 13'd5, 5'h2), 16'd4, "R3");
    rd_chk(2'd2, 13'd9, 32'd26, "R3");
    rd_chk(2'd1, 13'd5, {3'd5, 5'd17, 16'd50, 8'd7}, "R3");
    // R3: neither enable, still acknowledged
    release_only(mk_addr(3'd4, 0, 0, 8'd9, 13'd5, 5'h4), 16'd3, "R3");
    rd_chk(2'd2, 13'd9, 32'd26, "R3");

    // R5: clamp bucket, sticky flag
    release_only(mk_addr(3'd4, 0, 1, 8'd0, 13'd5, 5'h0), 16'd1000, "R5");
    check("R5", "bkt_uflow", {31'b0, bkt_uflow}, 32'h1);
    check("R5", "ring_uflow", {31'b0, ring_uflow}, 32'h0);
    rd_chk(2'd1, 13'd5, {3'd5, 5'd17, 16'd0, 8'd7}, "R5");
    cyc(0, '0, '0, 1, 13'd5, 0, '0, 0, 2'd0, '0, '0, "R6");
    check("R5", "bkt_uflow sticky", {31'b0, bkt_uflow}, 32'h1);
    rd_chk(2'd1, 13'd5, {3'd5, 5'd17, 16'd1, 8'd7}, "R6");

    // R6: same-cycle arrival and release on ring 9
    cyc(1, mk_addr(3'd4, 1, 0, 8'd9, 13'd0, 5'h6), 16'd5, 0, '0, 1, 8'd9, 0, 2'd0, '0, '0, "R6");
    rd_chk(2'd2, 13'd9, 32'd22, "R6");
    // R6: saturate at top
    init_write(2'd2, 13'd2, 32'h0000FFFF, "R8");
    cyc(0, '0, '0, 0, '0, 1, 8'd2, 0, 2'd0, '0, '0, "R6");
    rd_chk(2'd2, 13'd2, 32'h0000FFFF, "R6");
    // R6: arrival releases 1 from full with same-cycle release of 1 -> unchanged
    cyc(1, mk_addr(3'd4, 1, 0, 8'd2, 13'd0, 5'h0), 16'd1, 0, '0, 1, 8'd2, 0, 2'd0, '0, '0, "R6");
    rd_chk(2'd2, 13'd2, 32'h0000FFFF, "R6");

    // R10: out of range
    init_write(2'd1, 13'(BD), 32'hFFFFFFFF, "R10");
    rd_chk(2'd1, 13'(BD), 32'h0, "R10");
    init_write(2'd2, 13'(RD), 32'h1234, "R10");
    rd_chk(2'd2, 13'(RD), 32'h0, "R10");
    rd_chk(2'd2, 13'h102, 32'h0, "R10");

    // R8: init write wins over same-cycle release and arrival
    cyc(1, mk_addr(3'd4, 0, 1, 8'd0, 13'd5, 5'h0), 16'd1, 1, 13'd5, 0, '0,
        1, 2'd1, 13'd5, {3'd1, 5'd2, 16'd77, 8'd3}, "R8");
    rd_chk(2'd1, 13'd5, {3'd1, 5'd2, 16'd77, 8'd3}, "R8");
    rd_chk(2'd0, 13'd5, 32'h0, "R8");
    rd_chk(2'd3, 13'd5, 32'h0, "R8");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      logic [2:0] reg_f;
      logic [15:0] d;
      bit iw;
      logic [1:0] isel;
      reg_f = ($urandom % 2) ? 3'd4 : 3'($urandom % 8);
      a = mk_addr(reg_f, 1'($urandom), 1'($urandom), 8'($urandom % (RD + 4)),
                  13'($urandom % (BD + 4)), 5'($urandom));
      a[2:0] = 3'($urandom); a[34:29] = 6'($urandom);
      d = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 6);
      iw = ($urandom % 20 == 0);
      isel = 2'(1 + ($urandom % 2));
      cyc(($urandom % 3) != 0, a, d, ($urandom % 2) == 1, 13'($urandom % (BD + 2)),
          ($urandom % 2) == 1, 8'($urandom % (RD + 2)),
          iw, iw ? isel : 2'd0, 13'($urandom % BD), 32'($urandom) & 32'hFFFF03FF, "R2");
    end
    for (int i = 0; i < BD; i++) rd_chk(2'd1, 13'(i), m_bkt[i], "R4");
    for (int i = 0; i < RD; i++) rd_chk(2'd2, 13'(i), {16'h0, m_ring[i]}, "R6");
    check("R5", "bkt_uflow final", {31'b0, bkt_uflow}, {31'b0, m_bu});
    check("R5", "ring_uflow final", {31'b0, ring_uflow}, {31'b0, m_ru});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule